// File: doc/BRIEF.md
# SDRAM Open-Row Directory

This block sits beside an SDRAM memory controller that keeps rows open between accesses and interleaves over internal banks. It watches the controller's command stream (row open, column access, bank close, close-all for one chip select, auto refresh) and keeps a four-slot directory of the rows that are open now. Every slot records a chip select, an internal bank and a row. The directory is shared by all chip selects and internal banks. Within one chip select, each internal bank holds at most one open row.

For a pending access it answers in the same cycle. The answer is one of three classes. A hit means the row is already open. An idle miss means nothing is open in that internal bank. A conflict means another row is open in that bank, so the controller must close it before opening the new one. An idle miss that finds all four slots in use also raises a full flag, and a least-recently-used pointer names the slot to close first. Each chip select has a 3-bit geometry code. The code fixes how the byte address splits into column, bank and row fields, and it gives the page size.

Neither port group carries back-pressure. A command with `cmd_valid` high is consumed on that clock edge. A lookup with `lk_valid` high is answered combinationally in the same cycle. No ready signal exists, because the directory never stalls.

Top module: `opd_top`

## Requirements
- R1: After reset no slot is valid, `lru_valid` is 0, and every valid lookup reports idle.
- R2: The address is a byte address. Bits [1:0] are ignored, then come C column bits, then B bank bits, then R row bits. (C,B,R) per code: 1 → (9,1,11), 2 → (9,2,12), 3 → (9,2,13), 4 → (8,1,12), 5 → (8,2,11), 6 → (8,2,13), 7 → (9,1,13). Code 0 decodes as code 1. Chip select s uses `mode_cfg[3s+2:3s]`, and `lk_bank`/`lk_row` show the decoded lookup fields.
- R3: `lk_page_2k` is 1 (2 KB page) for codes 0, 1, 2, 3 and 7, and 0 (1 KB page) for codes 4, 5 and 6.
- R4: Command codes on `cmd_op` are 0 none, 1 open row, 2 column access, 3 close bank, 4 close all of a chip select, 5 refresh (6 and 7 do nothing). An open row to an idle bank fills the lowest-numbered free slot. When all slots are used it is ignored.
- R5: When `lk_valid` is 1, exactly one of hit, conflict and idle is set. A hit is set when chip select, bank and row all match a valid slot, and `lk_entry` then gives that slot.
- R6: A conflict is set when chip select and bank match a valid slot whose row differs, and `lk_entry` gives that slot.
- R7: `lk_full` is set exactly when the lookup is idle and all four slots are valid.
- R8: A close-bank command frees the slot holding that chip select and bank. A close-all command frees every slot of that chip select.
- R9: A refresh frees every slot on the same edge.
- R10: `lru_entry` names the valid slot whose most recent open or hitting column access is oldest, and `lru_valid` is set when any slot is valid. A column access that does not hit changes nothing.
- R11: A lookup in the same cycle as a command sees the directory as it was before that command.
- R12: With `lk_valid` at 0, hit, conflict, idle, full and `lk_entry` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_cfg | input | 12 | Geometry code per chip select, 3 bits each |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code |
| cmd_sel | input | 2 | Command chip select |
| cmd_addr | input | 26 | Command byte address |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_sel | input | 2 | Lookup chip select |
| lk_addr | input | 26 | Lookup byte address |
| lk_hit | output | 1 | Row already open |
| lk_conflict | output | 1 | Other row open in that bank |
| lk_idle | output | 1 | Bank has no open row |
| lk_full | output | 1 | Idle and no free slot |
| lk_entry | output | 2 | Slot matched by hit or conflict |
| lk_page_2k | output | 1 | Page size of the lookup's chip select |
| lk_bank | output | 2 | Decoded lookup bank |
| lk_row | output | 13 | Decoded lookup row |
| lru_entry | output | 2 | Least recently used valid slot |
| lru_valid | output | 1 | Some slot is valid |

## Verification
The assertions rely on the controller issuing one command per cycle. They also rely on it never opening a row in an internal bank that is already open without first closing it. The full check relies on an open row when all slots are used being dropped, not displacing anything. The random stimulus turns every open-row request aimed at an open bank into a close of that bank. When the directory is full, it usually closes the least recently used slot first, but it lets some open-row requests through so that the ignore path is exercised.

// File: rtl/opd_pkg.sv
package opd_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_ACT    = 3'd1,
    OP_RW     = 3'd2,
    OP_PRE    = 3'd3,
    OP_PREALL = 3'd4,
    OP_REF    = 3'd5
  } opd_op_e;

  typedef struct packed {
    logic [3:0] col_w;
    logic [1:0] bank_w;
    logic [3:0] row_w;
    logic       page_2k;
  } opd_geom_t;

  // Column width, bank width, row width and page size for each geometry code
  function automatic opd_geom_t opd_geom(input logic [2:0] mode);
    opd_geom_t g;
    case (mode)
      3'd2:    g = '{col_w: 4'd9, bank_w: 2'd2, row_w: 4'd12, page_2k: 1'b1};
      3'd3:    g = '{col_w: 4'd9, bank_w: 2'd2, row_w: 4'd13, page_2k: 1'b1};
      3'd4:    g = '{col_w: 4'd8, bank_w: 2'd1, row_w: 4'd12, page_2k: 1'b0};
      3'd5:    g = '{col_w: 4'd8, bank_w: 2'd2, row_w: 4'd11, page_2k: 1'b0};
      3'd6:    g = '{col_w: 4'd8, bank_w: 2'd2, row_w: 4'd13, page_2k: 1'b0};
      3'd7:    g = '{col_w: 4'd9, bank_w: 2'd1, row_w: 4'd13, page_2k: 1'b1};
      default: g = '{col_w: 4'd9, bank_w: 2'd1, row_w: 4'd11, page_2k: 1'b1};
    endcase
    return g;
  endfunction

endpackage

// File: rtl/opd_addr_split.sv
module opd_addr_split
  import opd_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2
) (
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic              page_2k
);

  opd_geom_t         g;
  logic [ADDR_W-1:0] above_col;
  logic [ADDR_W-1:0] above_bank;
  logic [ADDR_W-1:0] bank_mask;
  logic [ADDR_W-1:0] row_mask;

  always_comb begin
    g          = opd_geom(mode);
    // two byte-lane bits, then the column field
    above_col  = addr >> (32'd2 + 32'(g.col_w));
    above_bank = above_col >> g.bank_w;
    bank_mask  = (ADDR_W'(1) << g.bank_w) - ADDR_W'(1);
    row_mask   = (ADDR_W'(1) << g.row_w) - ADDR_W'(1);
    bank       = BANK_W'(above_col & bank_mask);
    row        = ROW_W'(above_bank & row_mask);
    page_2k    = g.page_2k;
  end

endmodule

// File: rtl/opd_dir_store.sv
module opd_dir_store #(
  parameter int NUM_ENT = 4,
  parameter int SEL_W   = 2,
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 13,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               do_act,
  input  logic               do_rw,
  input  logic               do_pre,
  input  logic               do_preall,
  input  logic               do_ref,
  input  logic [SEL_W-1:0]   c_sel,
  input  logic [BANK_W-1:0]  c_bank,
  input  logic [ROW_W-1:0]   c_row,
  input  logic [SEL_W-1:0]   l_sel,
  input  logic [BANK_W-1:0]  l_bank,
  input  logic [ROW_W-1:0]   l_row,
  output logic [NUM_ENT-1:0] valid,
  output logic [NUM_ENT-1:0] l_bmatch,
  output logic [NUM_ENT-1:0] l_rmatch,
  output logic               touch_en,
  output logic [IDX_W-1:0]   touch_idx
);

  logic [NUM_ENT-1:0] valid_q;
  logic [SEL_W-1:0]   sel_q  [NUM_ENT];
  logic [BANK_W-1:0]  bank_q [NUM_ENT];
  logic [ROW_W-1:0]   row_q  [NUM_ENT];

  logic [NUM_ENT-1:0] c_bmatch;
  logic [NUM_ENT-1:0] c_hit;
  logic [NUM_ENT-1:0] c_selhit;

  // per-slot comparators for the command and lookup sides
  for (genvar i = 0; i < NUM_ENT; i++) begin : g_cmp
    assign c_selhit[i] = valid_q[i] && (sel_q[i] == c_sel);
    assign c_bmatch[i] = c_selhit[i] && (bank_q[i] == c_bank);
    assign c_hit[i]    = c_bmatch[i] && (row_q[i] == c_row);
    assign l_bmatch[i] = valid_q[i] && (sel_q[i] == l_sel) && (bank_q[i] == l_bank);
    assign l_rmatch[i] = row_q[i] == l_row;
  end

  logic             has_free;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] bm_idx;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] act_tgt;
  logic             act_do;

  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    bm_idx   = '0;
    hit_idx  = '0;
    // descending scan so the lowest index wins
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (c_bmatch[i]) bm_idx = IDX_W'(i);
      if (c_hit[i])    hit_idx = IDX_W'(i);
    end
    act_tgt   = (|c_bmatch) ? bm_idx : free_idx;
    act_do    = do_act && ((|c_bmatch) || has_free);
    touch_en  = act_do || (do_rw && (|c_hit));
    touch_idx = act_do ? act_tgt : hit_idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < NUM_ENT; i++) begin
        sel_q[i]  <= '0;
        bank_q[i] <= '0;
        row_q[i]  <= '0;
      end
    end else if (do_ref) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (act_do && (act_tgt == IDX_W'(i))) begin
          valid_q[i] <= 1'b1;
          sel_q[i]   <= c_sel;
          bank_q[i]  <= c_bank;
          row_q[i]   <= c_row;
        end else if ((do_pre && c_bmatch[i]) || (do_preall && c_selhit[i])) begin
          valid_q[i] <= 1'b0;
        end
      end
    end
  end

  assign valid = valid_q;

endmodule

// File: rtl/opd_lru_order.sv
module opd_lru_order #(
  parameter int NUM_ENT = 4,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch_en,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic [NUM_ENT-1:0] valid,
  output logic [IDX_W-1:0]   lru_idx,
  output logic               lru_valid
);

  // older_q[i][j] set: slot i was used before slot j
  logic [NUM_ENT-1:0] older_q [NUM_ENT];
  logic [NUM_ENT-1:0] cand;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENT; i++)
        for (int j = 0; j < NUM_ENT; j++)
          older_q[i][j] <= 1'(i < j);
    end else if (touch_en) begin
      for (int i = 0; i < NUM_ENT; i++)
        for (int j = 0; j < NUM_ENT; j++) begin
          if ((IDX_W'(i) == touch_idx) && (i != j))
            older_q[i][j] <= 1'b0;
          else if ((IDX_W'(j) == touch_idx) && (i != j))
            older_q[i][j] <= 1'b1;
        end
    end
  end

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_cand
    always_comb begin
      cand[i] = valid[i];
      for (int j = 0; j < NUM_ENT; j++)
        if ((j != i) && valid[j] && !older_q[i][j]) cand[i] = 1'b0;
    end
  end

  always_comb begin
    lru_idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--)
      if (cand[i]) lru_idx = IDX_W'(i);
    lru_valid = |cand;
  end

endmodule

// File: rtl/opd_top.sv
module opd_top
  import opd_pkg::*;
#(
  parameter int NUM_ENT = 4,
  parameter int NUM_SEL = 4,
  parameter int ADDR_W  = 26,
  parameter int ROW_W   = 13,
  parameter int BANK_W  = 2,
  localparam int SEL_W  = $clog2(NUM_SEL),
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SEL*3-1:0] mode_cfg,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic [SEL_W-1:0]     cmd_sel,
  input  logic [ADDR_W-1:0]    cmd_addr,
  input  logic                 lk_valid,
  input  logic [SEL_W-1:0]     lk_sel,
  input  logic [ADDR_W-1:0]    lk_addr,
  output logic                 lk_hit,
  output logic                 lk_conflict,
  output logic                 lk_idle,
  output logic                 lk_full,
  output logic [IDX_W-1:0]     lk_entry,
  output logic                 lk_page_2k,
  output logic [BANK_W-1:0]    lk_bank,
  output logic [ROW_W-1:0]     lk_row,
  output logic [IDX_W-1:0]     lru_entry,
  output logic                 lru_valid
);

  logic [2:0]        c_mode;
  logic [2:0]        l_mode;
  logic [BANK_W-1:0] c_bank;
  logic [ROW_W-1:0]  c_row;
  logic              c_page_unused;

  assign c_mode = mode_cfg[32'(cmd_sel) * 3 +: 3];
  assign l_mode = mode_cfg[32'(lk_sel) * 3 +: 3];

  opd_addr_split #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_cmd_split (
    .mode(c_mode), .addr(cmd_addr), .bank(c_bank), .row(c_row), .page_2k(c_page_unused)
  );

  opd_addr_split #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_lk_split (
    .mode(l_mode), .addr(lk_addr), .bank(lk_bank), .row(lk_row), .page_2k(lk_page_2k)
  );

  logic do_act, do_rw, do_pre, do_preall, do_ref;
  always_comb begin
    do_act    = cmd_valid && (cmd_op == OP_ACT);
    do_rw     = cmd_valid && (cmd_op == OP_RW);
    do_pre    = cmd_valid && (cmd_op == OP_PRE);
    do_preall = cmd_valid && (cmd_op == OP_PREALL);
    do_ref    = cmd_valid && (cmd_op == OP_REF);
  end

  logic [NUM_ENT-1:0] ent_valid;
  logic [NUM_ENT-1:0] l_bmatch;
  logic [NUM_ENT-1:0] l_rmatch;
  logic               touch_en;
  logic [IDX_W-1:0]   touch_idx;

  opd_dir_store #(
    .NUM_ENT(NUM_ENT), .SEL_W(SEL_W), .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .do_act(do_act), .do_rw(do_rw), .do_pre(do_pre), .do_preall(do_preall), .do_ref(do_ref),
    .c_sel(cmd_sel), .c_bank(c_bank), .c_row(c_row),
    .l_sel(lk_sel), .l_bank(lk_bank), .l_row(lk_row),
    .valid(ent_valid), .l_bmatch(l_bmatch), .l_rmatch(l_rmatch),
    .touch_en(touch_en), .touch_idx(touch_idx)
  );

  opd_lru_order #(.NUM_ENT(NUM_ENT)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx),
    .valid(ent_valid), .lru_idx(lru_entry), .lru_valid(lru_valid)
  );

  // lookup answer from pre-command state
  logic             any_bank;
  logic             any_hit;
  logic [IDX_W-1:0] first_bm;

  always_comb begin
    any_bank = |l_bmatch;
    any_hit  = |(l_bmatch & l_rmatch);
    first_bm = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--)
      if (l_bmatch[i]) first_bm = IDX_W'(i);
    lk_hit      = lk_valid && any_hit;
    lk_conflict = lk_valid && any_bank && !any_hit;
    lk_idle     = lk_valid && !any_bank;
    lk_full     = lk_valid && !any_bank && (&ent_valid);
    lk_entry    = lk_valid ? first_bm : '0;
  end

endmodule

// File: rtl/opd_chk.sv
module opd_chk #(
  parameter int NUM_ENT = 4,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic [2:0]         cmd_op,
  input logic               lk_valid,
  input logic               lk_hit,
  input logic               lk_conflict,
  input logic               lk_idle,
  input logic               lk_full,
  input logic [IDX_W-1:0]   lru_entry,
  input logic               lru_valid,
  input logic [NUM_ENT-1:0] ent_valid
);

  // R5
  one_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot({lk_hit, lk_conflict, lk_idle}));

  // R7
  full_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_full |-> (lk_idle && (&ent_valid)));

  // R9
  ref_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd5) |=> (ent_valid == '0));

  // R8
  pre_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 3'd3 || cmd_op == 3'd4))
      |=> ($countones(ent_valid) <= $countones($past(ent_valid))));

  // R10
  lru_points_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lru_valid |-> ent_valid[lru_entry]);

  // R10
  lru_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lru_valid == (|ent_valid));

  // R12
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_conflict || lk_idle || lk_full));

  // R4
  act_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1 && !(&ent_valid)) |=> (ent_valid != '0));

endmodule

bind opd_top opd_chk #(.NUM_ENT(NUM_ENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_conflict(lk_conflict),
  .lk_idle(lk_idle), .lk_full(lk_full), .lru_entry(lru_entry),
  .lru_valid(lru_valid), .ent_valid(ent_valid)
);

// File: tb/sim_opd_top.sv
module sim_opd_top;

  localparam int AW = 26;

  logic        clk, rst_n;
  logic [11:0] mode_cfg;
  logic        cmd_valid, lk_valid;
  logic [2:0]  cmd_op;
  logic [1:0]  cmd_sel, lk_sel;
  logic [AW-1:0] cmd_addr, lk_addr;
  logic        lk_hit, lk_conflict, lk_idle, lk_full, lk_page_2k, lru_valid;
  logic [1:0]  lk_entry, lk_bank, lru_entry;
  logic [12:0] lk_row;

  opd_top u0 (
    .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sel(cmd_sel), .cmd_addr(cmd_addr),
    .lk_valid(lk_valid), .lk_sel(lk_sel), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_conflict(lk_conflict), .lk_idle(lk_idle), .lk_full(lk_full),
    .lk_entry(lk_entry), .lk_page_2k(lk_page_2k), .lk_bank(lk_bank), .lk_row(lk_row),
    .lru_entry(lru_entry), .lru_valid(lru_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // reference directory
  bit mv[4];
  int ms[4], mb[4], mr[4], mst[4];
  int stamp = 0;
  int cfg[4];

  // k: 0 column bits, 1 bank bits, 2 row bits, 3 page is 2 KB
  function automatic int geo(int m, int k);
    int t[4];
    case (m)
      2: t = '{9, 2, 12, 1};
      3: t = '{9, 2, 13, 1};
      4: t = '{8, 1, 12, 0};
      5: t = '{8, 2, 11, 0};
      6: t = '{8, 2, 13, 0};
      7: t = '{9, 1, 13, 1};
      default: t = '{9, 1, 11, 1};
    endcase
    return t[k];
  endfunction

  function automatic logic [AW-1:0] mk_addr(int m, int bank, int row, int col);
    int c = geo(m, 0);
    int b = geo(m, 1);
    return AW'((row << (2 + c + b)) | (bank << (2 + c)) | (col << 2));
  endfunction

  function automatic int dec_bank(int m, logic [AW-1:0] a);
    return int'(a >> (2 + geo(m, 0))) & ((1 << geo(m, 1)) - 1);
  endfunction

  function automatic int dec_row(int m, logic [AW-1:0] a);
    return int'(a >> (2 + geo(m, 0) + geo(m, 1))) & ((1 << geo(m, 2)) - 1);
  endfunction

  function automatic int find_bank(int s, int b);
    for (int i = 0; i < 4; i++)
      if (mv[i] && ms[i] == s && mb[i] == b) return i;
    return -1;
  endfunction

  function automatic bit m_full();
    return mv[0] && mv[1] && mv[2] && mv[3];
  endfunction

  function automatic int m_lru();
    int best = -1;
    for (int i = 0; i < 4; i++)
      if (mv[i] && (best < 0 || mst[i] < mst[best])) best = i;
    return best;
  endfunction

  function automatic int pick_valid();
    int st = int'($urandom % 4);
    for (int k = 0; k < 4; k++)
      if (mv[(st + k) % 4]) return (st + k) % 4;
    return -1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg();
    mode_cfg = {3'(cfg[3]), 3'(cfg[2]), 3'(cfg[1]), 3'(cfg[0])};
  endtask

  task automatic check_outputs();
    int m = cfg[lk_sel];
    int b = dec_bank(m, lk_addr);
    int r = dec_row(m, lk_addr);
    int e = find_bank(int'(lk_sel), b);
    int l = m_lru();
    chk("R2 lk_bank", int'(lk_bank), b);
    chk("R2 lk_row", int'(lk_row), r);
    chk("R3 lk_page_2k", int'(lk_page_2k), geo(m, 3));
    if (lk_valid) begin
      chk("R5 lk_hit", int'(lk_hit), int'(e >= 0 && mr[e] == r));
      chk("R6 lk_conflict", int'(lk_conflict), int'(e >= 0 && mr[e] != r));
      chk("R5 lk_idle", int'(lk_idle), int'(e < 0));
      chk("R7 lk_full", int'(lk_full), int'(e < 0 && m_full()));
      chk("R5 lk_entry", int'(lk_entry), (e >= 0) ? e : 0);
    end else begin
      chk("R12 flags quiet", int'({lk_hit, lk_conflict, lk_idle, lk_full}), 0);
      chk("R12 lk_entry quiet", int'(lk_entry), 0);
    end
    chk("R10 lru_valid", int'(lru_valid), int'(l >= 0));
    if (l >= 0) chk("R10 lru_entry", int'(lru_entry), l);
  endtask

  task automatic model_apply();
    int s, b, r, e;
    if (!cmd_valid) return;
    s = int'(cmd_sel);
    b = dec_bank(cfg[s], cmd_addr);
    r = dec_row(cfg[s], cmd_addr);
    e = find_bank(s, b);
    case (cmd_op)
      3'd1: begin
        if (e < 0)
          for (int i = 0; i < 4; i++)
            if (!mv[i]) begin e = i; break; end
        if (e >= 0) begin
          mv[e] = 1'b1; ms[e] = s; mb[e] = b; mr[e] = r; mst[e] = ++stamp;
        end
      end
      3'd2: if (e >= 0 && mr[e] == r) mst[e] = ++stamp;
      3'd3: if (e >= 0) mv[e] = 1'b0;
      3'd4: for (int i = 0; i < 4; i++) if (mv[i] && ms[i] == s) mv[i] = 1'b0;
      3'd5: for (int i = 0; i < 4; i++) mv[i] = 1'b0;
      default: ;
    endcase
  endtask

  // one clock: drive at the falling edge, check before the rising edge
  task automatic cyc(bit cv, int op, int s, logic [AW-1:0] ca,
                     bit lv, int ls, logic [AW-1:0] la);
    @(negedge clk);
    cmd_valid = cv; cmd_op = 3'(op); cmd_sel = 2'(s); cmd_addr = ca;
    lk_valid = lv; lk_sel = 2'(ls); lk_addr = la;
    #1;
    check_outputs();
    model_apply();
  endtask

  task automatic cmd(int op, int s, int b, int r);
    cyc(1'b1, op, s, mk_addr(cfg[s], b, r, 0), 1'b0, 0, '0);
  endtask

  task automatic look(int s, int b, int r);
    cyc(1'b0, 0, 0, '0, 1'b1, s, mk_addr(cfg[s], b, r, 7));
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin mv[i] = 1'b0; ms[i] = 0; mb[i] = 0; mr[i] = 0; mst[i] = 0; end
    cfg = '{1, 2, 5, 7};
    set_cfg();
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_sel = '0; cmd_addr = '0;
    lk_valid = 1'b0; lk_sel = '0; lk_addr = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    look(2, 1, 3);
    chk("R1 lru_valid after reset", int'(lru_valid), 0);
    chk("R1 idle after reset", int'(lk_idle), 1);

    // R2 / R3 geometry sweep on chip select 0, codes 0..7
    for (int m = 0; m < 8; m++) begin
      cfg[0] = m; set_cfg();
      look(0, 1, 5);
      chk("R2 sweep row", int'(lk_row), 5);
      chk("R2 sweep bank", int'(lk_bank), 1);
      chk("R3 sweep page", int'(lk_page_2k), (m >= 4 && m <= 6) ? 0 : 1);
      look(0, (1 << geo(m, 1)) - 1, (1 << geo(m, 2)) - 1);
      chk("R2 sweep max row", int'(lk_row), (1 << geo(m, 2)) - 1);
    end
    cfg[0] = 1; set_cfg();

    // R11 command and lookup together
    cyc(1'b1, 1, 1, mk_addr(cfg[1], 0, 9, 0), 1'b1, 1, mk_addr(cfg[1], 0, 9, 4));
    chk("R11 lookup sees pre-open state", int'(lk_idle), 1);
    look(1, 0, 9);
    chk("R11 hit on next cycle", int'(lk_hit), 1);

    // R4 fill lowest free slots, then ignore an open when full
    cmd(1, 1, 1, 4);
    cmd(1, 2, 0, 6);
    cmd(1, 3, 0, 2);
    look(2, 0, 6);
    chk("R4 third open lands in slot 2", int'(lk_entry), 2);
    cmd(1, 0, 0, 1);
    look(0, 0, 1);
    chk("R4 open ignored when full", int'(lk_idle), 1);
    chk("R7 full flag", int'(lk_full), 1);

    // R10 age order
    chk("R10 oldest is slot 0", int'(lru_entry), 0);
    cmd(2, 1, 0, 9);
    look(0, 0, 0);
    chk("R10 access moves slot 0 to newest", int'(lru_entry), 1);
    cmd(2, 1, 1, 3);
    look(0, 0, 0);
    chk("R10 missing access leaves order", int'(lru_entry), 1);

    // R6 conflict
    look(3, 0, 3);
    chk("R6 conflict", int'(lk_conflict), 1);
    chk("R6 conflict slot", int'(lk_entry), 3);

    // R8 close bank and close all
    cmd(3, 2, 0, 0);
    look(2, 0, 6);
    chk("R8 closed bank idle", int'(lk_idle), 1);
    cmd(1, 0, 1, 8);
    look(0, 1, 8);
    chk("R8 freed slot reused", int'(lk_entry), 2);
    cmd(4, 1, 0, 0);
    look(1, 1, 4);
    chk("R8 close-all frees select", int'(lk_idle), 1);
    look(0, 1, 8);
    chk("R8 other select kept", int'(lk_hit), 1);

    // R9 refresh
    cmd(5, 0, 0, 0);
    look(0, 1, 8);
    chk("R9 refresh clears", int'(lk_idle), 1);
    chk("R9 no valid slot", int'(lru_valid), 0);

    // constrained random mix
    for (int it = 0; it < 6000; it++) begin
      int r = int'($urandom % 100);
      int s = int'($urandom % 4);
      int b = int'($urandom) & ((1 << geo(cfg[s], 1)) - 1);
      int rw = ($urandom % 10 == 0) ? int'($urandom) & ((1 << geo(cfg[s], 2)) - 1)
                                     : int'($urandom % 4);
      int op, e, ls, lb, lr;
      bit cv = 1'b1, lv;
      if (r < 35) begin
        op = 1;
        if (find_bank(s, b) >= 0) op = 3;
        else if (m_full() && ($urandom % 4 != 0)) begin
          e = m_lru(); op = 3; s = ms[e]; b = mb[e]; rw = mr[e];
        end
      end else if (r < 60) begin
        op = 2; e = pick_valid();
        if (e >= 0 && $urandom % 10 < 7) begin s = ms[e]; b = mb[e]; rw = mr[e]; end
      end else if (r < 80) begin
        op = 3; e = pick_valid();
        if (e >= 0 && $urandom % 2 == 0) begin s = ms[e]; b = mb[e]; end
      end else if (r < 84) op = 4;
      else if (r < 86) op = 5;
      else begin op = int'($urandom % 8 >= 6 ? 6 + $urandom % 2 : 0); cv = $urandom % 2 == 0; end

      lv = ($urandom % 10) != 0;
      ls = int'($urandom % 4);
      lb = int'($urandom) & ((1 << geo(cfg[ls], 1)) - 1);
      lr = int'($urandom % 4);
      e = pick_valid();
      if (e >= 0 && $urandom % 10 < 6) begin
        ls = ms[e]; lb = mb[e]; lr = mr[e];
        if ($urandom % 4 == 0) lr = (lr + 1) & ((1 << geo(cfg[ls], 2)) - 1);
      end
      cyc(cv, op, s, mk_addr(cfg[s], b, rw, int'($urandom % 256)),
          lv, ls, mk_addr(cfg[ls], lb, lr, int'($urandom % 256)));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule